// File: doc/BRIEF.md
# PCI Base Address Register Window Decoder

This block is the device-side slice that holds one 32-bit base address register (BAR) and the two space-enable bits of the command register. The BAR claims a naturally aligned window whose size is a power of two. A parameter fixes that size, and a second parameter fixes whether the window lives in memory space or I/O space. Configuration software writes the BAR and the command register through a byte-enabled register port and reads them back on the same port. The read path responds in the same cycle, and a write takes effect at the next clock edge.

Because only the address bits above the window size can be written, writing all ones and reading back yields the size mask. While the register holds that probe value, the window is treated as unprogrammed and claims nothing. Writing a real aligned base moves the window at once.

An address-check port takes an address and a space indicator. It reports, without any clock delay, whether the address hits the window, and gives the offset of that address inside the window.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset the BAR address bits are 0, the command register reads 0 and `hit` is 0 for every address and space.
- R2: The BAR's low bits are read-only. For a memory window, bit 0 reads 0, bits 2:1 read the address-type parameter and bit 3 reads the prefetchable parameter. For an I/O window, bit 0 reads 1 and bit 1 reads 0.
- R3: Writing 0xFFFFFFFF to the BAR reads back the size mask ~(2^SIZE_LOG2 − 1) ORed with the read-only low bits. A 2 KB memory window that is not prefetchable therefore reads 0xFFFFF800.
- R4: BAR bits below SIZE_LOG2 that are not read-only always read 0, whatever value was written to them.
- R5: A write changes only the byte lanes whose `cfg_be` bit is 1. Lane k covers data bits 8k+7:8k. A write with all enables 0 changes nothing.
- R6: `cfg_sel`=0 selects the BAR and `cfg_sel`=1 selects the command register. In the command register, bit 0 is the I/O-space enable and bit 1 is the memory-space enable. Both are written through lane 0, and bits 31:2 read 0.
- R7: `hit` is 1 only when `chk_is_io` matches the window's space (1 means I/O) and the enable bit for that space is 1.
- R8: With decode enabled, `hit` is 1 for every address from base to base+2^SIZE_LOG2−1 inclusive, and 0 just below and just above that range.
- R9: `offset` equals `chk_addr` − base while `hit` is 1, and is 0 otherwise.
- R10: While every writable BAR bit is 1 (the probe value), `hit` stays 0. Writing the earlier base back restores decoding at that base.
- R11: A new base written to the BAR decides `hit` from the cycle after the write edge onward. The old base no longer hits from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 BAR, 1 command |
| cfg_be | input | 4 | Byte lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data of the selected register |
| chk_addr | input | 32 | Address to test against the window |
| chk_is_io | input | 1 | Space of the tested address: 1 I/O, 0 memory |
| hit | output | 1 | Address falls inside the enabled window |
| offset | output | SIZE_LOG2 | Offset of the address within the window |

## Verification
The bench sweeps addresses on both sides of each window edge, for every pair of enable settings and both spaces. It runs this sweep on a memory instance and on an I/O instance, and compares `hit` and `offset` against an arithmetic model of the register contents. Wrong stored base bits, or a wrong writable mask, show up at once as a changed `cfg_rdata` value, and they move the window edge by a power of two in the next sweep. A decoder that keeps decoding during a probe, or ignores an enable bit, shows a stray `hit` on the first address checked after that configuration write.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
   localparam int REG_W   = 32;
   localparam int LANES   = REG_W / 8;
   localparam int IO_MIN  = 2;
   localparam int MEM_MIN = 4;

   typedef enum logic {
      SEL_BAR = 1'b0,
      SEL_CMD = 1'b1
   } cfg_sel_e;

   function automatic logic [REG_W-1:0] size_mask(input int log2sz);
      return ~((REG_W'(1) << log2sz) - REG_W'(1));
   endfunction
endpackage

// File: rtl/bwd_bar_reg.sv
module bwd_bar_reg
   import bwd_pkg::*;
#(
   parameter int          SIZE_LOG2 = 11,
   parameter bit          IS_IO     = 1'b0,
   parameter logic [1:0]  ADDR_TYPE = 2'b00,
   parameter bit          PREFETCH  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LANES-1:0] be,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] bar_val,
   output logic [REG_W-1:0] base,
   output logic             unprog
);
   localparam logic [REG_W-1:0] WMASK = size_mask(SIZE_LOG2);

   logic [REG_W-1:0] stored_q;
   logic [REG_W-1:0] next_val;
   logic [REG_W-1:0] ro_bits;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign next_val[8*g +: 8] = (wr_en && be[g])
                                  ? (wdata[8*g +: 8] & WMASK[8*g +: 8])
                                  : stored_q[8*g +: 8];
   end

   if (IS_IO) begin : g_io_ro
      assign ro_bits = REG_W'(1);
   end else begin : g_mem_ro
      assign ro_bits = REG_W'({PREFETCH, ADDR_TYPE, 1'b0});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stored_q <= '0;
      else        stored_q <= next_val;
   end

   assign bar_val = stored_q | ro_bits;
   assign base    = stored_q;
   assign unprog  = (stored_q == WMASK);
endmodule

// File: rtl/bwd_cmd_reg.sv
module bwd_cmd_reg
   import bwd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             be0,
   input  logic [1:0]       wdata,
   output logic             io_en,
   output logic             mem_en,
   output logic [REG_W-1:0] cmd_val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_en  <= 1'b0;
         mem_en <= 1'b0;
      end else if (wr_en && be0) begin
         io_en  <= wdata[0];
         mem_en <= wdata[1];
      end
   end

   assign cmd_val = REG_W'({mem_en, io_en});
endmodule

// File: rtl/bwd_match.sv
module bwd_match
   import bwd_pkg::*;
#(
   parameter int SIZE_LOG2 = 11,
   parameter bit IS_IO     = 1'b0
) (
   input  logic                 io_en,
   input  logic                 mem_en,
   input  logic                 unprog,
   input  logic [REG_W-1:0]     base,
   input  logic [REG_W-1:0]     addr,
   input  logic                 is_io,
   output logic                 hit,
   output logic [SIZE_LOG2-1:0] offset
);
   localparam logic [REG_W-1:0] WMASK = size_mask(SIZE_LOG2);

   logic space_ok;
   logic in_range;

   if (IS_IO) begin : g_io_dec
      assign space_ok = is_io && io_en;
   end else begin : g_mem_dec
      assign space_ok = !is_io && mem_en;
   end

   assign in_range = ((addr & WMASK) == base);
   assign hit      = space_ok && in_range && !unprog;
   assign offset   = hit ? (addr[SIZE_LOG2-1:0] - base[SIZE_LOG2-1:0]) : '0;
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
   import bwd_pkg::*;
#(
   parameter int          SIZE_LOG2 = 11,
   parameter bit          IS_IO     = 1'b0,
   parameter logic [1:0]  ADDR_TYPE = 2'b00,
   parameter bit          PREFETCH  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic                 cfg_sel,
   input  logic [3:0]           cfg_be,
   input  logic [31:0]          cfg_wdata,
   output logic [31:0]          cfg_rdata,
   input  logic [31:0]          chk_addr,
   input  logic                 chk_is_io,
   output logic                 hit,
   output logic [SIZE_LOG2-1:0] offset
);
   localparam int MIN_LOG2 = IS_IO ? IO_MIN : MEM_MIN;

   if (SIZE_LOG2 < MIN_LOG2 || SIZE_LOG2 > REG_W - 1) begin : g_bad_size
      $error("bar_window_decoder: SIZE_LOG2 out of range for the chosen space");
   end
   if (!IS_IO && ADDR_TYPE != 2'b00) begin : g_bad_type
      $error("bar_window_decoder: only 32-bit memory windows are supported");
   end

   logic [REG_W-1:0] bar_val;
   logic [REG_W-1:0] base;
   logic             unprog;
   logic             io_en;
   logic             mem_en;
   logic [REG_W-1:0] cmd_val;
   logic             bar_wr;
   logic             cmd_wr;

   assign bar_wr = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_BAR);
   assign cmd_wr = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_CMD);

   bwd_bar_reg #(
      .SIZE_LOG2 (SIZE_LOG2),
      .IS_IO     (IS_IO),
      .ADDR_TYPE (ADDR_TYPE),
      .PREFETCH  (PREFETCH)
   ) bar_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bar_wr),
      .be      (cfg_be),
      .wdata   (cfg_wdata),
      .bar_val (bar_val),
      .base    (base),
      .unprog  (unprog)
   );

   bwd_cmd_reg cmd_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cmd_wr),
      .be0     (cfg_be[0]),
      .wdata   (cfg_wdata[1:0]),
      .io_en   (io_en),
      .mem_en  (mem_en),
      .cmd_val (cmd_val)
   );

   bwd_match #(
      .SIZE_LOG2 (SIZE_LOG2),
      .IS_IO     (IS_IO)
   ) match_i (
      .io_en  (io_en),
      .mem_en (mem_en),
      .unprog (unprog),
      .base   (base),
      .addr   (chk_addr),
      .is_io  (chk_is_io),
      .hit    (hit),
      .offset (offset)
   );

   assign cfg_rdata = cfg_sel ? cmd_val : bar_val;
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
   parameter int          SIZE_LOG2 = 11,
   parameter bit          IS_IO     = 1'b0,
   parameter logic [1:0]  ADDR_TYPE = 2'b00,
   parameter bit          PREFETCH  = 1'b0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_wr,
   input logic                 cfg_sel,
   input logic [3:0]           cfg_be,
   input logic [31:0]          cfg_rdata,
   input logic [31:0]          chk_addr,
   input logic                 chk_is_io,
   input logic                 hit,
   input logic [SIZE_LOG2-1:0] offset,
   input logic [31:0]          bar_val,
   input logic                 io_en,
   input logic                 mem_en
);
   localparam logic [31:0] LOWMASK = (32'd1 << SIZE_LOG2) - 32'd1;
   localparam logic [3:0]  RO_NIB  = IS_IO ? 4'b0001 : {PREFETCH, ADDR_TYPE, 1'b0};

   // R2 / R4: bits under the window size show only the fixed flags
   assert_low_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_val & LOWMASK) == (32'(RO_NIB) & LOWMASK));

   assert_ro_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_sel |-> cfg_rdata[3:0] == RO_NIB);

   assert_cmd_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sel |-> cfg_rdata[31:2] == 30'd0);

   assert_space_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (chk_is_io == IS_IO) && (IS_IO ? io_en : mem_en));

   assert_offset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> offset == '0);

   assert_no_probe_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((bar_val | LOWMASK) != 32'hFFFF_FFFF));

   assert_no_lane_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cfg_sel && cfg_be == 4'b0000) |=> $stable(bar_val));

   assert_hit_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((chk_addr & ~LOWMASK) == (bar_val & ~LOWMASK)));
endmodule

bind bar_window_decoder bwd_checker #(
   .SIZE_LOG2 (SIZE_LOG2),
   .IS_IO     (IS_IO),
   .ADDR_TYPE (ADDR_TYPE),
   .PREFETCH  (PREFETCH)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_sel   (cfg_sel),
   .cfg_be    (cfg_be),
   .cfg_rdata (cfg_rdata),
   .chk_addr  (chk_addr),
   .chk_is_io (chk_is_io),
   .hit       (hit),
   .offset    (offset),
   .bar_val   (bar_val),
   .io_en     (io_en),
   .mem_en    (mem_en)
);

// File: tb/bar_window_decoder_tb_top.sv
module bar_window_decoder_tb_top;
   localparam int M_L = 11;
   localparam int I_L = 5;
   localparam logic [31:0] M_WM = ~((32'd1 << M_L) - 32'd1);
   localparam logic [31:0] I_WM = ~((32'd1 << I_L) - 32'd1);
   localparam logic [31:0] M_RO = 32'h8;
   localparam logic [31:0] I_RO = 32'h1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_wr = 1'b0;
   logic         cfg_sel = 1'b0;
   logic [3:0]   cfg_be = 4'h0;
   logic [31:0]  cfg_wdata = '0;
   logic [31:0]  chk_addr = '0;
   logic         chk_is_io = 1'b0;
   logic [31:0]  m_rdata, i_rdata;
   logic         m_hit, i_hit;
   logic [M_L-1:0] m_off;
   logic [I_L-1:0] i_off;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] mod_m, mod_i;
   logic [1:0]  mod_cmd;

   always #4 clk = ~clk;

   bar_window_decoder #(.SIZE_LOG2(M_L), .IS_IO(1'b0), .ADDR_TYPE(2'b00), .PREFETCH(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(m_rdata), .chk_addr(chk_addr),
      .chk_is_io(chk_is_io), .hit(m_hit), .offset(m_off));

   bar_window_decoder #(.SIZE_LOG2(I_L), .IS_IO(1'b1), .ADDR_TYPE(2'b00), .PREFETCH(1'b0)) dut_io_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(i_rdata), .chk_addr(chk_addr),
      .chk_is_io(chk_is_io), .hit(i_hit), .offset(i_off));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] lane_merge(input logic [31:0] old, input logic [31:0] d,
                                              input logic [3:0] be, input logic [31:0] wm);
      logic [31:0] r = old;
      for (int k = 0; k < 4; k++)
         if (be[k]) r[8*k +: 8] = d[8*k +: 8] & wm[8*k +: 8];
      return r;
   endfunction

   task automatic wr(input logic sel, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_be = be; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (!sel) begin
         mod_m = lane_merge(mod_m, d, be, M_WM);
         mod_i = lane_merge(mod_i, d, be, I_WM);
      end else if (be[0]) begin
         mod_cmd = d[1:0];
      end
      #1;
   endtask

   task automatic read_bar(input string req);
      cfg_sel = 1'b0; #1;
      check(req, m_rdata, mod_m | M_RO);
      check(req, i_rdata, mod_i | I_RO);
   endtask

   task automatic probe_addr(input string req, input logic [31:0] a, input logic io);
      logic eh_m, eh_i;
      chk_addr = a; chk_is_io = io; #1;
      eh_m = !io && mod_cmd[1] && (mod_m != M_WM) && ((a & M_WM) == mod_m);
      eh_i =  io && mod_cmd[0] && (mod_i != I_WM) && ((a & I_WM) == mod_i);
      check({req, " mem hit"}, 32'(m_hit), 32'(eh_m));
      check({req, " mem offset"}, 32'(m_off), eh_m ? (a - mod_m) : 32'd0);
      check({req, " io hit"}, 32'(i_hit), 32'(eh_i));
      check({req, " io offset"}, 32'(i_off), eh_i ? (a - mod_i) : 32'd0);
   endtask

   task automatic sweep(input string req);
      logic [31:0] mo [6];
      logic [31:0] io [5];
      mo = '{32'hFFFF_FFFF, 32'd0, 32'd1, 32'h400, 32'h7FF, 32'h800};
      io = '{32'hFFFF_FFFF, 32'd0, 32'h10, 32'h1F, 32'h20};
      for (int s = 0; s < 2; s++) begin
         for (int k = 0; k < 6; k++) probe_addr(req, mod_m + mo[k], s[0]);
         for (int k = 0; k < 5; k++) probe_addr(req, mod_i + io[k], s[0]);
      end
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      mod_m = '0; mod_i = '0; mod_cmd = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state, R2 fixed low bits
      read_bar("R1 R2 reset bar");
      cfg_sel = 1'b1; #1;
      check("R1 cmd reset", m_rdata, 32'd0);
      probe_addr("R1 reset", 32'h0, 1'b0);
      probe_addr("R1 reset", 32'h0, 1'b1);

      // R3 size probe readback, R4 low bits zero
      wr(1'b0, 4'hF, 32'hFFFF_FFFF);
      cfg_sel = 1'b0; #1;
      check("R3 mem probe readback", m_rdata, 32'hFFFF_F808);
      check("R3 io probe readback", i_rdata, 32'hFFFF_FFE1);

      // R6 command register, enables both; R10 probe suppresses decode
      wr(1'b1, 4'h1, 32'hFFFF_FFFF);
      cfg_sel = 1'b1; #1;
      check("R6 cmd readback", m_rdata, 32'h3);
      check("R6 cmd readback io", i_rdata, 32'h3);
      probe_addr("R10 probe", 32'hFFFF_F800, 1'b0);
      probe_addr("R10 probe", 32'hFFFF_FFE0, 1'b1);

      // R4 garbage in low bits is dropped; R11 relocation
      wr(1'b0, 4'hF, 32'hF1BF_F8FF);
      read_bar("R4 R2 programmed");
      check("R4 mem exact", m_rdata, 32'hF1BF_F808);
      check("R4 io exact", i_rdata, 32'hF1BF_F8E1);

      // R7 R8 R9: sweep every enable combination
      for (int c = 0; c < 4; c++) begin
         wr(1'b1, 4'h1, 32'(c));
         sweep("R7 R8 R9 sweep");
      end

      // R5 byte lanes
      wr(1'b0, 4'b0100, 32'h1234_5678);
      read_bar("R5 lane2 write");
      check("R5 lane2 value", m_rdata, 32'hF134_F808);
      wr(1'b0, 4'b0000, 32'h0000_0000);
      read_bar("R5 no lanes");
      wr(1'b1, 4'b0000, 32'h0);
      cfg_sel = 1'b1; #1;
      check("R5 R6 cmd no lanes", m_rdata, 32'h3);
      sweep("R5 R8 after lane write");

      // R10 probe then restore; R11 old base stops hitting
      wr(1'b0, 4'hF, 32'hF1BF_F800);
      probe_addr("R11 restored", 32'hF1BF_F900, 1'b0);
      check("R11 restored hit", 32'(m_hit), 32'd1);
      wr(1'b0, 4'hF, 32'hFFFF_FFFF);
      probe_addr("R10 probe again", 32'hF1BF_F900, 1'b0);
      probe_addr("R10 probe value", 32'hFFFF_F800, 1'b0);
      wr(1'b0, 4'hF, 32'hF1BF_F800);
      probe_addr("R10 restore", 32'hF1BF_F800, 1'b0);
      check("R10 restore hit", 32'(m_hit), 32'd1);
      wr(1'b0, 4'hF, 32'hF1BF_F000);
      probe_addr("R11 old base", 32'hF1BF_F800, 1'b0);
      probe_addr("R11 new base", 32'hF1BF_F7FF, 1'b0);
      check("R11 new base hit", 32'(m_hit), 32'd1);
      sweep("R11 R8 relocated");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule